// File: doc/BRIEF.md
# Soft-Start Reference Ramp Generator

This block drives the digital reference code of a buck regulator's error loop during power-up. Once the supply leaves undervoltage lockout and the converter is enabled, the code climbs at a fixed slope toward the full-scale value that stands for the 800 mV regulation point. With the default parameters, one code step is 1 mV. A climb that starts at zero reaches full scale after a configured number of clock cycles, which is about 4 ms in the target system. When full scale is reached, a done flag rises. Power-good logic and the fault monitors downstream keep power-good low until this flag is high.

If the output capacitors already hold charge when the ramp starts, the measured residual level is loaded as the starting code. The ramp rises from that level with the same slope, so the output is never pulled down first. Lockout and disable each return the block to its idle state, and the next release starts a new ramp. The conversion of the code into a voltage is done elsewhere.

Top module: `ss_ramp_gen`

## Requirements
- R1: While `uvlo_i` is high, `ref_code_o` is 0 and `ss_done_o` is 0. This takes effect immediately, without waiting for a clock edge.
- R2: A rising clock edge that samples `disable_i` high sets `ref_code_o` to 0 and `ss_done_o` to 0.
- R3: At the first edge that samples both `uvlo_i` low and `disable_i` low while the block is idle, `ref_code_o` takes the value of `precharge_i`.
- R4: If the captured `precharge_i` is above FULL_SCALE, the start code is FULL_SCALE, and `ss_done_o` is high in that same cycle.
- R5: Starting from a precharge of 0, the code is floor(k*FULL_SCALE/RAMP_CYCLES) k edges after capture. It therefore reaches FULL_SCALE at exactly k = RAMP_CYCLES, and no single step exceeds ceil(FULL_SCALE/RAMP_CYCLES).
- R6: Starting from a precharge P, the code is min(FULL_SCALE, P + floor(k*FULL_SCALE/RAMP_CYCLES)) k edges after capture.
- R7: `ref_code_o` never exceeds FULL_SCALE. `ss_done_o` is high exactly when `ref_code_o` equals FULL_SCALE.
- R8: Once `ss_done_o` is high, it stays high until `disable_i` or `uvlo_i` is asserted.
- R9: Changes on `precharge_i` after the capture edge have no effect on the ramp.
- R10: While the block stays enabled, `ref_code_o` never decreases from one cycle to the next.
- R11: If `disable_i` is sampled high on the same edge at which the code would reach full scale, disable wins: the code goes to 0 and `ss_done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| uvlo_i | input | 1 | Supply lockout, active high, asynchronous |
| disable_i | input | 1 | Converter disable, active high, sampled on the clock |
| precharge_i | input | CODE_W | Measured residual output level as a code |
| ref_code_o | output | CODE_W | Reference code for the error loop |
| ss_done_o | output | 1 | High once the ramp has reached full scale |

## Verification
Two actions can fall due on the same edge: the ramp stepping onto full scale, which sets done, and a disable request, which clears the ramp. The bench sets up this collision by running a ramp from zero and raising disable one cycle before the full-scale step. It then expects a zero code with done low, and never a single cycle of done. A second collision occurs at release with an oversized precharge, where capture, clamping and done all happen on one edge. The bench checks that the code is full scale and done is already high in the first sample after that edge.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;

    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RAMP = 1'b1
    } ss_phase_e;

    function automatic int unsigned ss_ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/ss_step_gen.sv
module ss_step_gen #(
    parameter int unsigned CODE_W      = 10,
    parameter int unsigned FULL_SCALE  = 800,
    parameter int unsigned RAMP_CYCLES = 40
) (
    input  logic              clk_i,
    input  logic              uvlo_i,
    input  logic              clear_i,
    input  logic              adv_i,
    output logic [CODE_W-1:0] inc_o
);
    localparam int unsigned STEP_INT = FULL_SCALE / RAMP_CYCLES;
    localparam int unsigned STEP_REM = FULL_SCALE % RAMP_CYCLES;
    localparam int unsigned ACC_W    = $clog2(RAMP_CYCLES + 1);

    localparam logic [ACC_W:0]    REM_EXT = (ACC_W+1)'(STEP_REM);
    localparam logic [ACC_W:0]    CYC_EXT = (ACC_W+1)'(RAMP_CYCLES);
    localparam logic [CODE_W-1:0] STEP_C  = CODE_W'(STEP_INT);

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   acc_sum;
    logic             carry;

    // Fractional accumulator: spreads the remainder so k steps sum to floor(k*FS/N)
    always_comb begin
        acc_sum = {1'b0, acc_q} + REM_EXT;
        carry   = (acc_sum >= CYC_EXT);
        acc_d   = acc_q;
        if (clear_i) begin
            acc_d = '0;
        end else if (adv_i) begin
            acc_d = carry ? ACC_W'(acc_sum - CYC_EXT) : acc_sum[ACC_W-1:0];
        end
        inc_o = STEP_C + {{(CODE_W-1){1'b0}}, carry};
    end

    always_ff @(posedge clk_i or posedge uvlo_i) begin
        if (uvlo_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/ss_code_sat.sv
module ss_code_sat #(
    parameter int unsigned CODE_W     = 10,
    parameter int unsigned FULL_SCALE = 800
) (
    input  logic [CODE_W-1:0] base_i,
    input  logic [CODE_W-1:0] inc_i,
    output logic [CODE_W-1:0] sum_o,
    output logic              at_full_o
);
    localparam logic [CODE_W:0] FULL_EXT = (CODE_W+1)'(FULL_SCALE);

    logic [CODE_W:0] wide_sum;

    always_comb begin
        wide_sum  = {1'b0, base_i} + {1'b0, inc_i};
        at_full_o = (wide_sum >= FULL_EXT);
        sum_o     = at_full_o ? FULL_EXT[CODE_W-1:0] : wide_sum[CODE_W-1:0];
    end

endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen
    import ss_ramp_pkg::*;
#(
    parameter int unsigned CODE_W      = 10,
    parameter int unsigned FULL_SCALE  = 800,
    parameter int unsigned RAMP_CYCLES = 40
) (
    input  logic              clk_i,
    input  logic              uvlo_i,
    input  logic              disable_i,
    input  logic [CODE_W-1:0] precharge_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              ss_done_o
);
    localparam logic [CODE_W-1:0] FULL_CODE = CODE_W'(FULL_SCALE);
    localparam int unsigned       CODE_MAX  = (1 << CODE_W) - 1;

    typedef struct packed {
        ss_phase_e         phase;
        logic [CODE_W-1:0] code;
        logic              done;
    } ramp_state_t;

    ramp_state_t st_d, st_q;

    logic [CODE_W-1:0] start_code;
    logic [CODE_W-1:0] step_inc;
    logic [CODE_W-1:0] next_code;
    logic              next_full;
    logic              acc_clear;
    logic              acc_adv;

    // Clamp of the captured level, only built when the code range exceeds full scale
    generate
        if (CODE_MAX > FULL_SCALE) begin : g_clamp
            assign start_code = (precharge_i > FULL_CODE) ? FULL_CODE : precharge_i;
        end else begin : g_pass
            assign start_code = precharge_i;
        end
    endgenerate

    ss_step_gen #(
        .CODE_W      (CODE_W),
        .FULL_SCALE  (FULL_SCALE),
        .RAMP_CYCLES (RAMP_CYCLES)
    ) step_i (
        .clk_i   (clk_i),
        .uvlo_i  (uvlo_i),
        .clear_i (acc_clear),
        .adv_i   (acc_adv),
        .inc_o   (step_inc)
    );

    ss_code_sat #(
        .CODE_W     (CODE_W),
        .FULL_SCALE (FULL_SCALE)
    ) sat_i (
        .base_i    (st_q.code),
        .inc_i     (step_inc),
        .sum_o     (next_code),
        .at_full_o (next_full)
    );

    always_comb begin
        st_d      = st_q;
        acc_clear = 1'b0;
        acc_adv   = 1'b0;
        if (disable_i) begin
            st_d.phase = PH_HOLD;
            st_d.code  = '0;
            st_d.done  = 1'b0;
            acc_clear  = 1'b1;
        end else if (st_q.phase == PH_HOLD) begin
            st_d.phase = PH_RAMP;
            st_d.code  = start_code;
            st_d.done  = (start_code == FULL_CODE);
            acc_clear  = 1'b1;
        end else begin
            st_d.code = next_code;
            st_d.done = next_full;
            acc_adv   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge uvlo_i) begin
        if (uvlo_i) begin
            st_q <= '{phase: PH_HOLD, code: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_code_o = st_q.code;
    assign ss_done_o  = st_q.done;

endmodule

// File: rtl/ss_ramp_gen_chk.sv
module ss_ramp_gen_chk
    import ss_ramp_pkg::*;
#(
    parameter int unsigned CODE_W      = 10,
    parameter int unsigned FULL_SCALE  = 800,
    parameter int unsigned RAMP_CYCLES = 40
) (
    input logic              clk_i,
    input logic              uvlo_i,
    input logic              disable_i,
    input logic [CODE_W-1:0] precharge_i,
    input logic [CODE_W-1:0] ref_code_o,
    input logic              ss_done_o
);
    localparam int unsigned MAX_STEP = ss_ceil_div(FULL_SCALE, RAMP_CYCLES);

    // R7: the code is capped at full scale
    assert_code_cap_R7: assert property (@(posedge clk_i) disable iff (uvlo_i)
        int'(ref_code_o) <= FULL_SCALE);

    // R7: done is high exactly when the code is at full scale
    assert_done_match_R7: assert property (@(posedge clk_i) disable iff (uvlo_i)
        ss_done_o == (int'(ref_code_o) == FULL_SCALE));

    // R2: a sampled disable clears the code and done
    assert_disable_clear_R2: assert property (@(posedge clk_i) disable iff (uvlo_i)
        disable_i |=> (ref_code_o == '0) && !ss_done_o);

    // R8: done stays high while enabled
    assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (uvlo_i)
        (ss_done_o && !disable_i) |=> ss_done_o);

    // R10: the code does not decrease while enabled
    assert_monotonic_R10: assert property (@(posedge clk_i) disable iff (uvlo_i)
        !disable_i |=> ref_code_o >= $past(ref_code_o));

    // R5: a ramp step never exceeds the rounded-up step size
    assert_step_bound_R5: assert property (@(posedge clk_i) disable iff (uvlo_i)
        (!disable_i && ref_code_o != '0) |=>
            (int'(ref_code_o) - int'($past(ref_code_o))) <= int'(MAX_STEP));

    logic unused_ok;
    assign unused_ok = ^precharge_i;

endmodule

bind ss_ramp_gen ss_ramp_gen_chk #(
    .CODE_W      (CODE_W),
    .FULL_SCALE  (FULL_SCALE),
    .RAMP_CYCLES (RAMP_CYCLES)
) chk_i (
    .clk_i       (clk_i),
    .uvlo_i      (uvlo_i),
    .disable_i   (disable_i),
    .precharge_i (precharge_i),
    .ref_code_o  (ref_code_o),
    .ss_done_o   (ss_done_o)
);

// File: tb/ss_ramp_gen_tb.sv
module ss_ramp_gen_tb_top;
    localparam int CW  = 10;
    localparam int FS  = 800;
    localparam int CYC = 30;

    logic          clk = 1'b0;
    logic          uvlo;
    logic          dis;
    logic [CW-1:0] pre;
    logic [CW-1:0] code;
    logic          done;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    ss_ramp_gen #(.CODE_W(CW), .FULL_SCALE(FS), .RAMP_CYCLES(CYC)) dut_i (
        .clk_i       (clk),
        .uvlo_i      (uvlo),
        .disable_i   (dis),
        .precharge_i (pre),
        .ref_code_o  (code),
        .ss_done_o   (done)
    );

    function automatic int exp_code(input int p, input int k);
        int s;
        s = (p > FS) ? FS : p;
        s = s + (k * FS) / CYC;
        return (s > FS) ? FS : s;
    endfunction

    task automatic chk(input string req, input int got_c, input int got_d,
                       input int exp_c, input int exp_d);
        total++;
        if (got_c != exp_c || got_d != exp_d) begin
            bad++;
            $display("FAIL %s: code=%0d done=%0d expected code=%0d done=%0d",
                     req, got_c, got_d, exp_c, exp_d);
        end
    endtask

    // Releases disable with level p; checks k = 0..CYC+4; optionally scrambles precharge (R9)
    task automatic run_ramp(input int p, input bit scramble);
        dis = 1'b1;
        @(negedge clk);
        pre = CW'(p);
        dis = 1'b0;
        for (int k = 0; k <= CYC + 4; k++) begin
            @(negedge clk);
            if (scramble) pre = ~pre;
            chk(scramble ? "R9" : (p == 0 ? "R5" : (p > FS ? "R4" : "R6")),
                int'(code), int'(done), exp_code(p, k), int'(exp_code(p, k) == FS));
        end
    endtask

    initial begin
        uvlo = 1'b1;
        dis  = 1'b0;
        pre  = '0;
        #1;
        chk("R1", int'(code), int'(done), 0, 0);
        repeat (3) @(negedge clk);
        chk("R1", int'(code), int'(done), 0, 0);
        uvlo = 1'b0;

        // R3 R5 R6 R4: sweep of precharge levels across the whole code range
        for (int p = 0; p < 1024; p += 41) run_ramp(p, 1'b0);
        run_ramp(FS - 1, 1'b0);
        run_ramp(FS, 1'b0);
        run_ramp(FS + 1, 1'b0);
        run_ramp(1023, 1'b0);

        // R9: precharge toggling after capture
        run_ramp(123, 1'b1);

        // R3: first sample after release equals precharge
        dis = 1'b1;
        @(negedge clk);
        pre = CW'(333);
        dis = 1'b0;
        @(negedge clk);
        chk("R3", int'(code), int'(done), 333, 0);

        // R2: disable mid-ramp
        dis = 1'b1;
        @(negedge clk);
        chk("R2", int'(code), int'(done), 0, 0);
        @(negedge clk);
        chk("R2", int'(code), int'(done), 0, 0);

        // R11: disable coincides with the full-scale step
        pre = '0;
        dis = 1'b0;
        for (int k = 0; k < CYC; k++) @(negedge clk);
        chk("R11", int'(code), int'(done), exp_code(0, CYC - 1), 0);
        dis = 1'b1;
        @(negedge clk);
        chk("R11", int'(code), int'(done), 0, 0);
        @(negedge clk);
        chk("R11", int'(code), int'(done), 0, 0);

        // R1: lockout acts without a clock edge; R8 done sticky until then
        dis = 1'b0;
        pre = CW'(FS);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8", int'(code), int'(done), FS, 1);
        end
        #1 uvlo = 1'b1;
        #1;
        chk("R1", int'(code), int'(done), 0, 0);
        @(negedge clk);
        pre  = CW'(50);
        uvlo = 1'b0;
        @(negedge clk);
        chk("R3", int'(code), int'(done), 50, 0);
        @(negedge clk);
        chk("R6", int'(code), int'(done), exp_code(50, 1), 0);

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog: code=%0d done=%0d expected completion", code, done);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule